// File: doc/BRIEF.md
# Code Segment Write Protection Guard

This block checks each write or erase request aimed at program memory and decides whether it may go ahead. A three-bit segment setting picks the protected range: no segment protection, everything from a boundary page up to the top of implemented memory, or everything from address zero up to and including the boundary page. The last of these can also cover the final page of memory, where the configuration words are kept. An 8-bit page number gives the boundary page.

A separate global lock input stands in for the chip-wide protection settings. When it is high, every request is refused. Addresses beyond the implemented memory are always refused. The result comes back one clock after the request as either a grant or a deny. A sticky violation flag records that at least one request was refused, and only reset clears it. The page size, the implemented memory size and the address width are parameters. The page size must be a power of two, and a page's first address is its page number times the page size.

Top module: `cswp_guard`

## Requirements
- R1: After reset, resp_valid_o, grant_o, deny_o and violation_o are all 0.
- R2: With seg_off_i=1, global_lock_i=0 and an address below MEM_WORDS, every request is granted, whatever the other segment bits and the boundary page hold.
- R3: With seg_off_i=0 and seg_upper_i=1, a request is denied exactly when addr_i >= bound_page_i*PAGE_WORDS. This range includes the last page.
- R4: With seg_off_i=0, seg_upper_i=0 and seg_cfgpg_i=1, a request is denied exactly when addr_i <= bound_page_i*PAGE_WORDS + PAGE_WORDS - 1.
- R5: With seg_off_i=0, seg_upper_i=0 and seg_cfgpg_i=0, a request is denied when addr_i <= bound_page_i*PAGE_WORDS + PAGE_WORDS - 1. It is also denied when addr_i >= MEM_WORDS - PAGE_WORDS, which is the last page.
- R6: A request with addr_i >= MEM_WORDS is always denied.
- R7: When req_i is 1 at a rising edge, the result appears after that same edge. resp_valid_o is then 1, and exactly one of grant_o and deny_o is 1. When req_i is 0 at an edge, all three of these outputs are 0 after it.
- R8: When global_lock_i is 1, every request is denied.
- R9: violation_o goes to 1 together with the first deny_o and stays at 1 until reset.
- R10: While req_i is 0, changes on the address, segment, page and lock inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | A write or erase request is present this cycle |
| addr_i | input | ADDR_W | Target program memory address |
| seg_off_i | input | 1 | 1 turns segment protection off |
| seg_upper_i | input | 1 | 1 protects from the boundary page to the top of memory |
| seg_cfgpg_i | input | 1 | In low-range mode, 0 also protects the last (configuration) page |
| bound_page_i | input | 8 | Boundary page number |
| global_lock_i | input | 1 | Chip-wide protection; 1 refuses every request |
| resp_valid_o | output | 1 | A result is on grant_o / deny_o |
| grant_o | output | 1 | The request is allowed |
| deny_o | output | 1 | The request is refused |
| violation_o | output | 1 | Sticky flag: a refused request has been seen |

## Verification
The assertions assume that reset is held long enough to cover at least one rising edge. They also assume that the segment bits, the boundary page and the address stay fixed during each edge where req_i is sampled, which lets a result be tied to the request one cycle earlier. The bench applies every stimulus on the falling edge and drops req_i between requests, so each result is read back in isolation. Its sweeps cover all four segment settings and all 256 boundary pages. They use a small configuration in which implemented memory does not fill the address space, so out-of-memory addresses get exercised too.

// File: rtl/cswp_pkg.sv
package cswp_pkg;

  typedef enum logic [1:0] {
    SEG_NONE      = 2'd0,
    SEG_UPPER     = 2'd1,
    SEG_LOWER     = 2'd2,
    SEG_LOWER_CFG = 2'd3
  } seg_mode_e;

  // Segment setting priority: off first, then upper, then the config page choice.
  function automatic seg_mode_e decode_mode(input logic off, input logic upper,
                                            input logic cfgpg);
    if (off)        return SEG_NONE;
    else if (upper) return SEG_UPPER;
    else if (cfgpg) return SEG_LOWER;
    else            return SEG_LOWER_CFG;
  endfunction

  // First word address of a page.
  function automatic logic [31:0] page_first(input logic [7:0] pg,
                                             input int unsigned pw_log2);
    return 32'(pg) << pw_log2;
  endfunction

  // Last word address of a page (inclusive).
  function automatic logic [31:0] page_last(input logic [7:0] pg,
                                            input int unsigned pw_log2);
    return page_first(pg, pw_log2) + ((32'd1 << pw_log2) - 32'd1);
  endfunction

endpackage

// File: rtl/cswp_range_dec.sv
module cswp_range_dec
  import cswp_pkg::*;
#(
  parameter int unsigned PAGE_WORDS = 64,
  parameter int unsigned MEM_WORDS  = 3072
) (
  input  logic        seg_off_i,
  input  logic        seg_upper_i,
  input  logic        seg_cfgpg_i,
  input  logic [7:0]  bound_page_i,
  output seg_mode_e   mode_o,
  output logic [31:0] floor_o,
  output logic [31:0] ceil_o,
  output logic [31:0] cfg_first_o
);
  localparam int unsigned PW_LOG2 = $clog2(PAGE_WORDS);
  localparam logic [31:0] CFG_FIRST = 32'(MEM_WORDS - PAGE_WORDS);

  always_comb begin
    mode_o      = decode_mode(seg_off_i, seg_upper_i, seg_cfgpg_i);
    floor_o     = page_first(bound_page_i, PW_LOG2);
    ceil_o      = page_last(bound_page_i, PW_LOG2);
    cfg_first_o = CFG_FIRST;
  end

  // r4_/r3_: a page always spans PAGE_WORDS words
  always_comb begin
    assert (ceil_o - floor_o == 32'(PAGE_WORDS - 1))
      else $error("a_r4_page_span");
  end
endmodule

// File: rtl/cswp_decide.sv
module cswp_decide
  import cswp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned MEM_WORDS = 3072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  seg_mode_e         mode_i,
  input  logic [31:0]       floor_i,
  input  logic [31:0]       ceil_i,
  input  logic [31:0]       cfg_first_i,
  input  logic              global_lock_i,
  output logic              seg_hit_o,
  output logic              out_of_mem_o,
  output logic              deny_o
);
  logic [31:0] a32;
  logic        above_floor;
  logic        below_ceil;
  logic        in_cfg_page;

  always_comb begin
    a32          = 32'(addr_i);
    above_floor  = a32 >= floor_i;
    below_ceil   = a32 <= ceil_i;
    in_cfg_page  = a32 >= cfg_first_i;
    out_of_mem_o = a32 >= 32'(MEM_WORDS);
    unique case (mode_i)
      SEG_NONE:      seg_hit_o = 1'b0;
      SEG_UPPER:     seg_hit_o = above_floor;
      SEG_LOWER:     seg_hit_o = below_ceil;
      SEG_LOWER_CFG: seg_hit_o = below_ceil | in_cfg_page;
      default:       seg_hit_o = 1'b1;
    endcase
    deny_o = global_lock_i | out_of_mem_o | seg_hit_o;
  end

  // R5: in low-range mode with the config page, the last page is always hit
  a_r5_cfg_page_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SEG_LOWER_CFG && !out_of_mem_o && a32 >= 32'(MEM_WORDS) - (ceil_i - floor_i + 32'd1))
      |-> seg_hit_o);

  // R3: upper mode never hits below the boundary page
  a_r3_no_hit_below_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SEG_UPPER && a32 < floor_i) |-> !seg_hit_o);
endmodule

// File: rtl/cswp_resp_reg.sv
module cswp_resp_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic deny_c_i,
  output logic resp_valid_o,
  output logic grant_o,
  output logic deny_o,
  output logic violation_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      grant_o      <= 1'b0;
      deny_o       <= 1'b0;
      violation_o  <= 1'b0;
    end else begin
      resp_valid_o <= req_i;
      grant_o      <= req_i & ~deny_c_i;
      deny_o       <= req_i & deny_c_i;
      violation_o  <= violation_o | (req_i & deny_c_i);
    end
  end

  // R9: the flag never drops without reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o |=> violation_o);

  // R9: a deny is always reflected in the flag
  a_r9_set_with_deny: assert property (@(posedge clk) disable iff (!rst_n)
    deny_o |-> violation_o);
endmodule

// File: rtl/cswp_guard.sv
module cswp_guard
  import cswp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned PAGE_WORDS = 64,
  parameter int unsigned MEM_WORDS  = 3072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              seg_off_i,
  input  logic              seg_upper_i,
  input  logic              seg_cfgpg_i,
  input  logic [7:0]        bound_page_i,
  input  logic              global_lock_i,
  output logic              resp_valid_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              violation_o
);
  seg_mode_e   mode_w;
  logic [31:0] floor_w;
  logic [31:0] ceil_w;
  logic [31:0] cfg_first_w;
  logic        seg_hit_w;
  logic        out_of_mem_w;
  logic        deny_c_w;

  cswp_range_dec #(.PAGE_WORDS(PAGE_WORDS), .MEM_WORDS(MEM_WORDS)) range_i (
    .seg_off_i    (seg_off_i),
    .seg_upper_i  (seg_upper_i),
    .seg_cfgpg_i  (seg_cfgpg_i),
    .bound_page_i (bound_page_i),
    .mode_o       (mode_w),
    .floor_o      (floor_w),
    .ceil_o       (ceil_w),
    .cfg_first_o  (cfg_first_w)
  );

  cswp_decide #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) decide_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_i        (addr_i),
    .mode_i        (mode_w),
    .floor_i       (floor_w),
    .ceil_i        (ceil_w),
    .cfg_first_i   (cfg_first_w),
    .global_lock_i (global_lock_i),
    .seg_hit_o     (seg_hit_w),
    .out_of_mem_o  (out_of_mem_w),
    .deny_o        (deny_c_w)
  );

  cswp_resp_reg resp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .deny_c_i     (deny_c_w),
    .resp_valid_o (resp_valid_o),
    .grant_o      (grant_o),
    .deny_o       (deny_o),
    .violation_o  (violation_o)
  );

  a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> resp_valid_o);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!resp_valid_o && !grant_o && !deny_o));

  a_r7_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |-> $onehot({grant_o, deny_o}));

  a_r8_lock_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && global_lock_i) |=> deny_o);

  a_r6_out_of_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && out_of_mem_w) |=> deny_o);

  a_r2_off_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && seg_off_i && !global_lock_i && !out_of_mem_w) |=> grant_o);

  a_r3_upper_protects: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !seg_off_i && seg_upper_i && seg_hit_w) |=> deny_o);
endmodule

// File: tb/cswp_guard_tb.sv
module cswp_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PS = 16;
  localparam int MW = 768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic s_off = 1'b0, s_up = 1'b0, s_cfg = 1'b0, lock = 1'b0;
  logic [7:0] bp = '0;
  logic rv, gr, dn, vi;

  int checks = 0;
  int failures = 0;
  bit exp_viol = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cswp_guard #(.ADDR_W(AW), .PAGE_WORDS(PS), .MEM_WORDS(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
    .seg_off_i(s_off), .seg_upper_i(s_up), .seg_cfgpg_i(s_cfg),
    .bound_page_i(bp), .global_lock_i(lock),
    .resp_valid_o(rv), .grant_o(gr), .deny_o(dn), .violation_o(vi)
  );

  function automatic bit model_deny(int a, bit off, bit up, bit cfg, int pg, bit lk);
    int lo_end;
    lo_end = pg * PS + PS - 1;
    if (lk) return 1'b1;
    if (a >= MW) return 1'b1;
    if (off) return 1'b0;
    if (up) return a >= pg * PS;
    if (cfg) return a <= lo_end;
    return (a <= lo_end) || (a >= MW - PS);
  endfunction

  function automatic string tag_of(int a, bit off, bit up, bit cfg, bit lk);
    if (lk) return "R8";
    if (a >= MW) return "R6";
    if (off) return "R2";
    if (up) return "R3";
    if (cfg) return "R4";
    return "R5";
  endfunction

  task automatic check(string req_tag, bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, exp);
    end
  endtask

  task automatic do_req(int a, bit off, bit up, bit cfg, int pg, bit lk);
    bit e;
    string t;
    e = model_deny(a, off, up, cfg, pg, lk);
    t = tag_of(a, off, up, cfg, lk);
    @(negedge clk);
    req = 1'b1; addr = AW'(a); s_off = off; s_up = up; s_cfg = cfg;
    bp = 8'(pg); lock = lk;
    @(negedge clk);
    req = 1'b0;
    if (e) exp_viol = 1'b1;
    check(t, rv == 1'b1 && gr == !e && dn == e, "grant/deny",
          {29'd0, rv, gr, dn}, {29'd0, 1'b1, !e, e});
    check("R9", vi == exp_viol, "violation", int'(vi), int'(exp_viol));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_viol = 1'b0;
    check("R1", {rv, gr, dn, vi} == 4'b0, "reset state", int'({rv, gr, dn, vi}), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R9: grants alone never raise the flag
    do_req(3, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    do_req(100, 1'b0, 1'b1, 1'b0, 20, 1'b0);
    // R10: idle input activity is ignored
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      addr = AW'(k * 97); s_off = k[0]; s_up = k[1]; s_cfg = k[2]; bp = 8'(k * 33);
      lock = ~k[0];
      @(negedge clk);
      check("R10", {rv, gr, dn, vi} == {3'b000, exp_viol}, "idle outputs",
            int'({rv, gr, dn, vi}), int'({3'b000, exp_viol}));
    end
    // R2/R3/R4/R5/R6: every boundary page, around its edges, all modes
    for (int m = 0; m < 4; m++) begin
      do_reset();
      for (int pg = 0; pg < 256; pg++) begin
        for (int o = 0; o < 4; o++) begin
          int a;
          a = pg * PS + (o == 0 ? -1 : o == 1 ? 0 : o == 2 ? PS - 1 : PS);
          if (a >= 0 && a < (1 << AW))
            do_req(a, m == 0, m == 1, m == 2, pg, 1'b0);
        end
      end
    end
    // Full address sweeps for a few boundary pages
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        int pg;
        pg = (p == 0) ? 0 : (p == 1) ? 5 : (p == 2) ? 47 : 60;
        do_reset();
        for (int a = 0; a < (1 << AW); a++)
          do_req(a, m == 0, m == 1, m == 2, pg, 1'b0);
      end
    end
    // R8: lock overrides every mode
    do_reset();
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < (1 << AW); a += 61)
        do_req(a, m == 0, m == 1, m == 2, 30, 1'b1);
    // R9: flag holds through later grants, and reset clears it
    do_req(5, 1'b1, 1'b0, 1'b0, 0, 1'b0);
    check("R9", vi == 1'b1, "violation held", int'(vi), 1);
    do_reset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule